// File: doc/BRIEF.md
# Streaming Serial Control-Bus Slave

This block is the target side of a four-wire serial host bus: active-low select, serial clock, a host-to-slave data line and a slave-to-host data line with an output enable for a three-state pad. Every transaction opens with an address byte. That byte alone picks the transfer class: command, single-byte write, single-byte read, streaming write or streaming read. A streaming transfer lets one address be followed by any number of data bytes, back to back or with pauses, all aimed at the same register while select stays low.

On the inside it presents the decoded register address, a one-cycle write strobe carrying each assembled byte, a one-cycle read request whose returned byte is shifted out, a command strobe, and a reset pulse for the designated command code. All bus pins are taken as already synchronous to `clk`; clock edges are found by comparing the serial clock with its value one `clk` cycle earlier.

Top module: `stream_ctl_slave`

## Requirements
- R1: Address and data bytes are captured most-significant bit first on rising serial-clock edges while `cs_n` is low; `reg_addr` takes the address after its eighth bit.
- R2: Five address masks classify each address (defaults: command 0x01 and 0x02, single write 0x10, single read 0x11, streaming write 0x20, streaming read 0x21); any other address produces no strobe, request or output drive until `cs_n` rises.
- R3: A command address raises `cmd_stb` for one cycle with the code on `reg_addr`; `reset_pulse` rises in that same cycle only when the code equals `RESET_CODE` (default 0x01). A command takes no data bytes.
- R4: A single write raises exactly one `wr_stb` after the eighth data bit, with the byte on `wr_data`; further clocks in the same transaction are ignored.
- R5: A streaming write raises `wr_stb` after every eighth data bit, each at the same `reg_addr`, with or without idle time between bytes.
- R6: A read raises `rd_req` at the eighth address bit; `rd_data` must be valid during that cycle. The byte is driven MSB first on `sdo`, each bit changing only after a falling serial-clock edge, starting at the falling edge after the address.
- R7: A streaming read raises a further `rd_req` at the eighth rising edge of every data byte, ahead of the next byte leaving the pin; a read of N bytes therefore issues N+1 requests.
- R8: `sdo_oe` is high only during the data phase of a read; for a single read it drops at the falling edge after the byte, and it is never high during an address or write byte.
- R9: When `cs_n` goes high, state and bit count clear, `sdo_oe` drops next cycle, and a partial byte produces no strobe.
- R10: The serial clock may idle high or low between transactions without changing the result.
- R11: `wr_stb`, `rd_req` and `cmd_stb` are single-cycle and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Bus select, active low |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Host-to-slave data |
| sdo | output | 1 | Slave-to-host data |
| sdo_oe | output | 1 | Output enable for the `sdo` pad |
| reg_addr | output | 8 | Decoded register or command address |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_data | output | 8 | Assembled write byte |
| rd_req | output | 1 | One-cycle read request |
| rd_data | input | 8 | Read byte, valid while `rd_req` is high |
| cmd_stb | output | 1 | One-cycle command strobe |
| reset_pulse | output | 1 | One-cycle reset for the reset command |

## Verification
The assertions rely on the serial clock holding each level for at least three `clk` cycles, so a rising and a falling edge never fall in the same or adjacent cycles and the returned read byte is latched before the next falling edge. They also rely on `rd_data` being valid in the cycle `rd_req` is high. The bench drives every serial half period for three `clk` cycles, answers read requests combinationally from its own counter, and changes pins only on the falling edge of `clk`.

// File: rtl/stream_ctl_slave.sv
module stream_ctl_slave #(
  parameter logic [255:0] CMD_MAP = (256'd1 << 8'h01) | (256'd1 << 8'h02),
  parameter logic [255:0] WR1_MAP = 256'd1 << 8'h10,
  parameter logic [255:0] RD1_MAP = 256'd1 << 8'h11,
  parameter logic [255:0] WRS_MAP = 256'd1 << 8'h20,
  parameter logic [255:0] RDS_MAP = 256'd1 << 8'h21,
  parameter logic [7:0]   RESET_CODE = 8'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       sdi,
  output logic       sdo,
  output logic       sdo_oe,
  output logic [7:0] reg_addr,
  output logic       wr_stb,
  output logic [7:0] wr_data,
  output logic       rd_req,
  input  logic [7:0] rd_data,
  output logic       cmd_stb,
  output logic       reset_pulse
);
  typedef enum logic [1:0] {ADDR, WDAT, RDAT, HOLD} st_t;

  st_t        st;
  logic       sclk_q, stream, load_pend;
  logic [2:0] cnt;
  logic [7:0] sh, obuf, osh;

  wire       rise = !cs_n && sclk && !sclk_q;
  wire       fall = !cs_n && !sclk && sclk_q;
  wire [7:0] nxt  = {sh[6:0], sdi};
  wire       last = (cnt == 3'd7);

  assign sdo = osh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ADDR; sclk_q <= 1'b0; stream <= 1'b0; load_pend <= 1'b0;
      cnt <= '0; sh <= '0; obuf <= '0; osh <= '0; sdo_oe <= 1'b0;
      reg_addr <= '0; wr_stb <= 1'b0; wr_data <= '0; rd_req <= 1'b0;
      cmd_stb <= 1'b0; reset_pulse <= 1'b0;
    end else begin
      sclk_q <= sclk;
      wr_stb <= 1'b0; rd_req <= 1'b0; cmd_stb <= 1'b0; reset_pulse <= 1'b0;
      if (rd_req) obuf <= rd_data;
      if (cs_n) begin
        st <= ADDR; cnt <= '0; sdo_oe <= 1'b0; load_pend <= 1'b0;
      end else begin
        if (rise) begin
          cnt <= cnt + 3'd1;
          sh  <= nxt;
          case (st)
            ADDR: if (last) begin
              reg_addr <= nxt;
              if (CMD_MAP[nxt]) begin
                cmd_stb <= 1'b1; reset_pulse <= (nxt == RESET_CODE); st <= HOLD;
              end else if (WR1_MAP[nxt] || WRS_MAP[nxt]) begin
                st <= WDAT; stream <= WRS_MAP[nxt];
              end else if (RD1_MAP[nxt] || RDS_MAP[nxt]) begin
                st <= RDAT; stream <= RDS_MAP[nxt]; rd_req <= 1'b1; load_pend <= 1'b1;
              end else begin
                st <= HOLD;
              end
            end
            WDAT: if (last) begin
              wr_stb <= 1'b1; wr_data <= nxt;
              if (!stream) st <= HOLD;
            end
            RDAT: if (last) begin
              if (stream) begin rd_req <= 1'b1; load_pend <= 1'b1; end
              else st <= HOLD;
            end
            default: ;
          endcase
        end
        if (fall) begin
          if (st == RDAT && load_pend) begin
            osh <= obuf; load_pend <= 1'b0; sdo_oe <= 1'b1;
          end else if (st == RDAT) begin
            osh <= {osh[6:0], 1'b0};
          end else begin
            sdo_oe <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/stream_ctl_slave_chk.sv
module stream_ctl_slave_chk #(
  parameter logic [7:0] RESET_CODE = 8'h01
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sclk,
  input logic       sdo,
  input logic       sdo_oe,
  input logic [7:0] reg_addr,
  input logic       wr_stb,
  input logic       rd_req,
  input logic       cmd_stb,
  input logic       reset_pulse
);
  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_stb, rd_req, cmd_stb}));

  assert_wr_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  assert_rd_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  assert_reset_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reset_pulse |-> (cmd_stb && reg_addr == RESET_CODE));

  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !sdo_oe);

  assert_fall_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && $past(sdo_oe) && !$stable(sdo)) |-> !$past(sclk));

  assert_oe_rises_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> (!$past(sclk) && !$past(cs_n)));
endmodule

bind stream_ctl_slave stream_ctl_slave_chk #(.RESET_CODE(RESET_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe),
  .reg_addr(reg_addr), .wr_stb(wr_stb), .rd_req(rd_req), .cmd_stb(cmd_stb),
  .reset_pulse(reset_pulse)
);

// File: tb/sim_stream_ctl_slave.sv
module sim_stream_ctl_slave;
  localparam int CLK_NS = 10;
  localparam int H = 3;

  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, sdi = 0;
  logic sdo, sdo_oe, wr_stb, rd_req, cmd_stb, reset_pulse;
  logic [7:0] reg_addr, wr_data, rd_data;
  logic [7:0] rd_cnt = 0;
  int errors = 0, checks = 0, oe_bad = 0;
  logic [17:0] q[$];

  always #(CLK_NS/2) clk = ~clk;

  stream_ctl_slave u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .reg_addr(reg_addr), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_req(rd_req), .rd_data(rd_data), .cmd_stb(cmd_stb), .reset_pulse(reset_pulse));

  assign rd_data = 8'hA0 + rd_cnt;
  always @(posedge clk) if (rd_req) rd_cnt <= rd_cnt + 8'd1;

  task automatic check(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s got=%0h exp=%0h", req, got, exp); end
  endtask

  // kind: 0 write, 1 read request, 2 command, 3 reset command
  task automatic expect_ev(input logic [1:0] k, input logic [7:0] a, input logic [7:0] d);
    q.push_back({k, a, d});
  endtask

  task automatic got_ev(input logic [1:0] k, input logic [7:0] a, input logic [7:0] d);
    logic [17:0] e;
    if (q.size() == 0) begin
      check(0, "R2 R4 unexpected event", {k, a, d}, 0);
    end else begin
      e = q.pop_front();
      if (k == 2'd1) check(e[17:8] == {k, a}, "R7 read request", {k, a}, e[17:8]);
      else check(e == {k, a, d}, "R3 R5 event", {k, a, d}, e);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (wr_stb)  got_ev(2'd0, reg_addr, wr_data);
    if (rd_req)  got_ev(2'd1, reg_addr, 8'd0);
    if (cmd_stb) got_ev(reset_pulse ? 2'd3 : 2'd2, reg_addr, 8'd0);
    if (reset_pulse && !cmd_stb) check(0, "R3 lone reset", 1, 0);
  end

  task automatic bit_x(input logic b, output logic got, output logic oe);
    repeat (H) @(negedge clk);
    sclk = 0; sdi = b;
    repeat (H) @(negedge clk);
    got = sdo; oe = sdo_oe;
    sclk = 1;
  endtask

  task automatic xbyte(input logic [7:0] o, input bit rd, output logic [7:0] i);
    logic b, oe;
    for (int k = 7; k >= 0; k--) begin
      bit_x(o[k], b, oe);
      i[k] = b;
      if (oe != rd) oe_bad++;
    end
  endtask

  task automatic t_begin(input logic idle);
    @(negedge clk); sclk = idle;
    repeat (H) @(negedge clk); cs_n = 0;
  endtask

  task automatic t_end(input logic idle);
    repeat (H) @(negedge clk); sclk = idle;
    repeat (H) @(negedge clk); cs_n = 1;
    repeat (2*H) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R1 got=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic [7:0] base;
    repeat (3) @(negedge clk);
    check(!sdo_oe && !wr_stb && !rd_req && !cmd_stb && !reset_pulse, "R8 reset state",
          {sdo_oe, wr_stb, rd_req, cmd_stb}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R3 reset command, idle low (R10)
    expect_ev(2'd3, 8'h01, 8'd0);
    t_begin(0); xbyte(8'h01, 0, r); t_end(0);
    // R3 plain command, idle high (R10)
    expect_ev(2'd2, 8'h02, 8'd0);
    t_begin(1); xbyte(8'h02, 0, r); t_end(1);

    // R4 single write, extra byte ignored; R1 MSB first
    expect_ev(2'd0, 8'h10, 8'h5A);
    t_begin(0); xbyte(8'h10, 0, r); xbyte(8'h5A, 0, r); xbyte(8'hFF, 0, r); t_end(0);

    // R5 streaming write with gaps, idle high
    expect_ev(2'd0, 8'h20, 8'h11); expect_ev(2'd0, 8'h20, 8'h22); expect_ev(2'd0, 8'h20, 8'h33);
    t_begin(1); xbyte(8'h20, 0, r);
    xbyte(8'h11, 0, r); repeat (20) @(negedge clk);
    xbyte(8'h22, 0, r); repeat (7) @(negedge clk);
    xbyte(8'h33, 0, r); t_end(1);

    // R5 streaming write back to back
    expect_ev(2'd0, 8'h20, 8'hC3); expect_ev(2'd0, 8'h20, 8'h3C);
    t_begin(0); xbyte(8'h20, 0, r); xbyte(8'hC3, 0, r); xbyte(8'h3C, 0, r); t_end(0);
    check(oe_bad == 0, "R8 no drive in address or write bytes", oe_bad, 0);

    // R6 single read, then trailing clocks with output released
    base = rd_cnt;
    expect_ev(2'd1, 8'h11, 8'd0);
    t_begin(1); xbyte(8'h11, 0, r); xbyte(8'h00, 1, r);
    check(r == 8'hA0 + base, "R6 single read byte", r, 8'hA0 + base);
    oe_bad = 0;
    xbyte(8'h00, 0, r);
    check(oe_bad == 0, "R8 released after single read", oe_bad, 0);
    t_end(1);

    // R7 streaming read, three bytes, N+1 requests
    base = rd_cnt;
    for (int k = 0; k < 4; k++) expect_ev(2'd1, 8'h21, 8'd0);
    t_begin(0); xbyte(8'h21, 0, r);
    for (int k = 0; k < 3; k++) begin
      xbyte(8'h00, 1, r);
      check(r == 8'hA0 + base + k[7:0], "R7 streaming read byte", r, 8'hA0 + base + k[7:0]);
      if (k == 1) repeat (9) @(negedge clk);
    end
    t_end(0);
    repeat (2) @(negedge clk);
    check(!sdo_oe, "R9 release on select high", sdo_oe, 0);

    // R2 unknown address ignored
    oe_bad = 0;
    t_begin(0); xbyte(8'h55, 0, r); xbyte(8'h77, 0, r); xbyte(8'h21, 0, r); t_end(0);
    check(oe_bad == 0, "R2 unknown address no drive", oe_bad, 0);

    // R9 abort in data byte, then a clean write
    t_begin(0); xbyte(8'h20, 0, r);
    for (int k = 0; k < 5; k++) begin logic b, oe; bit_x(1'b1, b, oe); end
    t_end(0);
    expect_ev(2'd0, 8'h10, 8'h99);
    t_begin(1); xbyte(8'h10, 0, r); xbyte(8'h99, 0, r); t_end(1);

    // R9 abort inside the address byte, then a command
    t_begin(0);
    for (int k = 0; k < 3; k++) begin logic b, oe; bit_x(1'b0, b, oe); end
    t_end(0);
    expect_ev(2'd2, 8'h02, 8'd0);
    t_begin(0); xbyte(8'h02, 0, r); t_end(0);

    repeat (10) @(negedge clk);
    check(q.size() == 0, "R1 all expected events seen", q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule